// File: doc/BRIEF.md
# Write-Back Invalidation Snoop Controller

This block is the coherence controller of one private, direct-mapped, one-word-per-line cache in a shared-bus multiprocessor. Each line is Invalid, Shared (clean, read-only) or Exclusive (the sole copy, writable and dirty). Processor reads and writes that can be served from the line finish locally. Every other access asks an external arbiter for the bus. Once granted, the controller writes back a dirty victim if there is one, then places a read miss or a write miss, and only then updates the line.

The same controller watches every transaction that other caches put on the bus. A foreign write miss removes a matching local copy. A foreign read miss or write miss to a locally dirty line makes the controller hand the block over and tell memory to abandon its own reply. The line then drops to Shared or Invalid. Snoops always win the tag lookup. If a snoop changes the line that a waiting processor request targets, that request is dropped and looked up again.

Top module: `wbi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, all bus and snoop outputs are idle, and the first access to any address misses.
- R2: A processor read to an Invalid line raises a read miss (bus code 2'b01) at the requested address and returns the filled word. The line becomes Shared, so the next read of that address hits with no bus traffic.
- R3: A processor write to a line that is Invalid, or Shared with any tag, raises a write miss (bus code 2'b10) with no write-back, and the line becomes Exclusive.
- R4: Read hits and write hits on an Exclusive line cause no bus command and complete in the cycle after the lookup.
- R5: A miss that replaces an Exclusive line with another tag first drives a write-back (bus code 2'b11) carrying the victim address and data. The very next cycle carries the read miss or write miss.
- R6: A read miss that replaces a Shared line issues only a read miss, with no write-back, and leaves the line Shared under the new tag.
- R7: A snooped write miss (snoop code 2'b10) to a block held Shared invalidates it, without supplying data or aborting, so a later read misses.
- R8: A snooped read miss (snoop code 2'b01) to a block held Exclusive raises supply and abort together, with the dirty word, in the cycle after the snoop. The line becomes Shared: reads then hit and a write goes to the bus.
- R9: A snooped write miss to a block held Exclusive raises supply and abort with the dirty word in the cycle after the snoop, and the line becomes Invalid.
- R10: While waiting for the grant the controller keeps its request up, drives no command and changes no line. A snoop that changes the pending line drops the request for one cycle, and the access restarts with a fresh lookup.
- R11: A snoop present in the same cycle as a new processor request takes the lookup. The processor result arrives one cycle later than it otherwise would.
- R12: A snooped read miss to a Shared block, or any snoop whose tag does not match, causes no supply, no abort and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req_i | input | 1 | Processor access request, held until ready |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Word address; low bits index the line |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_ready_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | DATA_W | Read data, valid with ready |
| bus_req_o | output | 1 | Request to the bus arbiter |
| bus_gnt_i | input | 1 | Grant from the bus arbiter |
| bus_cmd_o | output | 2 | 00 idle, 01 read miss, 10 write miss, 11 write-back |
| bus_addr_o | output | ADDR_W | Address of the driven command |
| bus_data_o | output | DATA_W | Write-back data |
| fill_data_i | input | DATA_W | Data returned during a read miss |
| snoop_cmd_i | input | 2 | Foreign bus command, same encoding |
| snoop_addr_i | input | ADDR_W | Foreign bus address |
| snoop_abort_o | output | 1 | Memory must abandon its reply |
| snoop_supply_o | output | 1 | This cache supplies the block |
| snoop_data_o | output | DATA_W | Supplied dirty word |

## Verification
A lookup happens on the clock edge after the request is presented. A hit raises ready one cycle later. A miss with an immediate grant raises ready three cycles after the request, or four when a write-back is needed. The bench counts falling edges from the request to ready and compares that count with the figure its own line model predicts. Snoop responses are due exactly one cycle after the snoop cycle, and the check that a pending request restarted samples the request in that same cycle. All samples are taken on falling edges. The sweep repeats the whole state sequence on every line index.

// File: rtl/wbi_pkg.sv
`timescale 1ns/1ps
package wbi_pkg;
    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_EXC = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        BC_IDLE   = 2'd0,
        BC_RDMISS = 2'd1,
        BC_WRMISS = 2'd2,
        BC_WBACK  = 2'd3
    } bus_cmd_e;

    typedef enum logic [2:0] {
        CT_IDLE = 3'd0,
        CT_REQ  = 3'd1,
        CT_WB   = 3'd2,
        CT_FILL = 3'd3,
        CT_RESP = 3'd4
    } ctl_st_e;
endpackage

// File: rtl/wbi_line_store.sv
`timescale 1ns/1ps
module wbi_line_store #(
    parameter int LINES  = 8,
    parameter int TAG_W  = 5,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [1:0]        rd_a_st,
    output logic [TAG_W-1:0]  rd_a_tag,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [1:0]        rd_b_st,
    output logic [TAG_W-1:0]  rd_b_tag,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [1:0]        wr_st,
    input  logic              wr_data_en,
    input  logic [DATA_W-1:0] wr_data
);
    typedef struct packed {
        logic [1:0]        st;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } line_t;

    line_t lines_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        line_t ln_d, ln_q;

        always_comb begin
            ln_d = ln_q;
            if (wr_en && wr_idx == IDX_W'(g)) begin
                ln_d.st  = wr_st;
                ln_d.tag = wr_tag;
                if (wr_data_en) begin
                    ln_d.data = wr_data;
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ln_q <= '0;
            end else begin
                ln_q <= ln_d;
            end
        end

        assign lines_q[g] = ln_q;
    end

    assign rd_a_st   = lines_q[rd_a_idx].st;
    assign rd_a_tag  = lines_q[rd_a_idx].tag;
    assign rd_a_data = lines_q[rd_a_idx].data;
    assign rd_b_st   = lines_q[rd_b_idx].st;
    assign rd_b_tag  = lines_q[rd_b_idx].tag;
    assign rd_b_data = lines_q[rd_b_idx].data;

    // R1: only the three defined line states are ever written
    a_r1_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_st != 2'b11));
endmodule

// File: rtl/wbi_snoop_resolve.sv
`timescale 1ns/1ps
module wbi_snoop_resolve #(
    parameter int TAG_W = 5
) (
    input  logic [1:0]       cmd,
    input  logic [TAG_W-1:0] tag,
    input  logic [1:0]       ln_st,
    input  logic [TAG_W-1:0] ln_tag,
    output logic             change,
    output logic             supply,
    output logic [1:0]       new_st
);
    import wbi_pkg::*;

    logic match;

    always_comb begin
        match  = (ln_st != LN_INV) && (ln_tag == tag);
        change = 1'b0;
        supply = 1'b0;
        new_st = ln_st;
        if (match && cmd == BC_WRMISS) begin
            change = 1'b1;
            supply = (ln_st == LN_EXC);
            new_st = LN_INV;
        end else if (match && cmd == BC_RDMISS && ln_st == LN_EXC) begin
            change = 1'b1;
            supply = 1'b1;
            new_st = LN_SHR;
        end
    end
endmodule

// File: rtl/wbi_cpu_lookup.sv
`timescale 1ns/1ps
module wbi_cpu_lookup #(
    parameter int TAG_W = 5
) (
    input  logic             we,
    input  logic [TAG_W-1:0] tag,
    input  logic [1:0]       ln_st,
    input  logic [TAG_W-1:0] ln_tag,
    output logic             local_hit,
    output logic             need_wb
);
    import wbi_pkg::*;

    logic same;

    always_comb begin
        same = (ln_tag == tag);
        if (we) begin
            local_hit = same && (ln_st == LN_EXC);
        end else begin
            local_hit = same && (ln_st != LN_INV);
        end
        need_wb = !same && (ln_st == LN_EXC);
    end
endmodule

// File: rtl/wbi_snoop_ctrl.sv
`timescale 1ns/1ps
module wbi_snoop_ctrl #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int LINES  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_i,
    input  logic              cpu_we_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic [DATA_W-1:0] cpu_wdata_i,
    output logic              cpu_ready_o,
    output logic [DATA_W-1:0] cpu_rdata_o,
    output logic              bus_req_o,
    input  logic              bus_gnt_i,
    output logic [1:0]        bus_cmd_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_data_o,
    input  logic [DATA_W-1:0] fill_data_i,
    input  logic [1:0]        snoop_cmd_i,
    input  logic [ADDR_W-1:0] snoop_addr_i,
    output logic              snoop_abort_o,
    output logic              snoop_supply_o,
    output logic [DATA_W-1:0] snoop_data_o
);
    import wbi_pkg::*;

    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        ctl_st_e           st;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              wb;
        logic [DATA_W-1:0] rdata;
        logic              abort;
        logic              supply;
        logic [DATA_W-1:0] sdata;
    } ctl_t;

    ctl_t d, q;

    logic [IDX_W-1:0]  a_idx;
    logic [1:0]        a_st, b_st;
    logic [TAG_W-1:0]  a_tag, b_tag;
    logic [DATA_W-1:0] a_data, b_data;
    logic              wr_en, wr_data_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [TAG_W-1:0]  wr_tag;
    logic [1:0]        wr_st;
    logic [DATA_W-1:0] wr_data;
    logic              lk_hit, lk_wb;
    logic              rs_change, rs_supply;
    logic [1:0]        rs_st;
    logic              snp_on, snp_ok;

    assign a_idx = (q.st == CT_IDLE) ? cpu_addr_i[IDX_W-1:0] : q.addr[IDX_W-1:0];

    wbi_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_a_idx   (a_idx),
        .rd_a_st    (a_st),
        .rd_a_tag   (a_tag),
        .rd_a_data  (a_data),
        .rd_b_idx   (snoop_addr_i[IDX_W-1:0]),
        .rd_b_st    (b_st),
        .rd_b_tag   (b_tag),
        .rd_b_data  (b_data),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_tag     (wr_tag),
        .wr_st      (wr_st),
        .wr_data_en (wr_data_en),
        .wr_data    (wr_data)
    );

    wbi_cpu_lookup #(.TAG_W(TAG_W)) lookup_i (
        .we        (cpu_we_i),
        .tag       (cpu_addr_i[ADDR_W-1:IDX_W]),
        .ln_st     (a_st),
        .ln_tag    (a_tag),
        .local_hit (lk_hit),
        .need_wb   (lk_wb)
    );

    wbi_snoop_resolve #(.TAG_W(TAG_W)) resolve_i (
        .cmd    (snoop_cmd_i),
        .tag    (snoop_addr_i[ADDR_W-1:IDX_W]),
        .ln_st  (b_st),
        .ln_tag (b_tag),
        .change (rs_change),
        .supply (rs_supply),
        .new_st (rs_st)
    );

    always_comb begin
        d          = q;
        d.abort    = 1'b0;
        d.supply   = 1'b0;
        wr_en      = 1'b0;
        wr_idx     = '0;
        wr_tag     = '0;
        wr_st      = LN_INV;
        wr_data_en = 1'b0;
        wr_data    = '0;

        snp_on = (snoop_cmd_i == BC_RDMISS) || (snoop_cmd_i == BC_WRMISS);
        snp_ok = snp_on && (q.st == CT_IDLE || q.st == CT_REQ || q.st == CT_RESP);

        // snoop side: state change plus data hand-over
        if (snp_ok && rs_change) begin
            wr_en    = 1'b1;
            wr_idx   = snoop_addr_i[IDX_W-1:0];
            wr_tag   = b_tag;
            wr_st    = rs_st;
            d.abort  = rs_supply;
            d.supply = rs_supply;
            d.sdata  = b_data;
        end

        // processor side
        case (q.st)
            CT_IDLE: begin
                if (cpu_req_i && !snp_on) begin
                    d.we    = cpu_we_i;
                    d.addr  = cpu_addr_i;
                    d.wdata = cpu_wdata_i;
                    if (lk_hit) begin
                        if (cpu_we_i) begin
                            wr_en      = 1'b1;
                            wr_idx     = cpu_addr_i[IDX_W-1:0];
                            wr_tag     = a_tag;
                            wr_st      = LN_EXC;
                            wr_data_en = 1'b1;
                            wr_data    = cpu_wdata_i;
                        end else begin
                            d.rdata = a_data;
                        end
                        d.st = CT_RESP;
                    end else begin
                        d.wb = lk_wb;
                        d.st = CT_REQ;
                    end
                end
            end
            CT_REQ: begin
                if (snp_on) begin
                    if (rs_change && snoop_addr_i[IDX_W-1:0] == q.addr[IDX_W-1:0]) begin
                        d.st = CT_IDLE;
                    end
                end else if (bus_gnt_i) begin
                    d.st = q.wb ? CT_WB : CT_FILL;
                end
            end
            CT_WB: begin
                d.st = CT_FILL;
            end
            CT_FILL: begin
                wr_en      = 1'b1;
                wr_idx     = q.addr[IDX_W-1:0];
                wr_tag     = q.addr[ADDR_W-1:IDX_W];
                wr_st      = q.we ? LN_EXC : LN_SHR;
                wr_data_en = 1'b1;
                wr_data    = q.we ? q.wdata : fill_data_i;
                if (!q.we) begin
                    d.rdata = fill_data_i;
                end
                d.st = CT_RESP;
            end
            CT_RESP: begin
                d.st = CT_IDLE;
            end
            default: begin
                d.st = CT_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        bus_cmd_o  = BC_IDLE;
        bus_addr_o = '0;
        bus_data_o = '0;
        if (q.st == CT_WB) begin
            bus_cmd_o  = BC_WBACK;
            bus_addr_o = {a_tag, q.addr[IDX_W-1:0]};
            bus_data_o = a_data;
        end else if (q.st == CT_FILL) begin
            bus_cmd_o  = q.we ? BC_WRMISS : BC_RDMISS;
            bus_addr_o = q.addr;
        end
    end

    assign bus_req_o      = (q.st == CT_REQ) || (q.st == CT_WB) || (q.st == CT_FILL);
    assign cpu_ready_o    = (q.st == CT_RESP);
    assign cpu_rdata_o    = q.rdata;
    assign snoop_abort_o  = q.abort;
    assign snoop_supply_o = q.supply;
    assign snoop_data_o   = q.sdata;

    // R10: with the request up and no grant, the next cycle carries no command
    a_r10_no_cmd_before_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_gnt_i && bus_cmd_o == BC_IDLE) |=> (bus_cmd_o == BC_IDLE));

    // R5: a write-back is always followed at once by the miss itself
    a_r5_wb_then_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd_o == BC_WBACK) |=> (bus_cmd_o == BC_RDMISS || bus_cmd_o == BC_WRMISS));

    // R8: data is only supplied in answer to a foreign miss one cycle earlier
    a_r8_supply_needs_snoop: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_supply_o |-> ($past(snoop_cmd_i) == BC_RDMISS || $past(snoop_cmd_i) == BC_WRMISS));

    // R11: a snoop in the lookup cycle stalls the processor
    a_r11_snoop_stalls_cpu: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == CT_IDLE && cpu_req_i && snp_on) |=> !cpu_ready_o);

    // R2: completion only follows a held request
    a_r2_ready_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready_o |-> $past(cpu_req_i));
endmodule

// File: tb/wbi_snoop_ctrl_tb_top.sv
`timescale 1ns/1ps
module wbi_snoop_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_req, cpu_we, cpu_ready;
    logic [7:0]  cpu_addr;
    logic [15:0] cpu_wdata, cpu_rdata;
    logic        bus_req, bus_gnt, hold_gnt;
    logic [1:0]  bus_cmd;
    logic [7:0]  bus_addr;
    logic [15:0] bus_data, fill_data;
    logic [1:0]  snoop_cmd;
    logic [7:0]  snoop_addr;
    logic        snp_abort, snp_supply;
    logic [15:0] snp_data;

    logic [15:0] mem [256];
    int          m_st  [8];
    logic [4:0]  m_tag [8];
    logic [15:0] m_dat [8];

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    assign bus_gnt   = bus_req & ~hold_gnt;
    assign fill_data = mem[bus_addr];

    wbi_snoop_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
        .cpu_wdata_i(cpu_wdata), .cpu_ready_o(cpu_ready), .cpu_rdata_o(cpu_rdata),
        .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .bus_cmd_o(bus_cmd),
        .bus_addr_o(bus_addr), .bus_data_o(bus_data), .fill_data_i(fill_data),
        .snoop_cmd_i(snoop_cmd), .snoop_addr_i(snoop_addr),
        .snoop_abort_o(snp_abort), .snoop_supply_o(snp_supply), .snoop_data_o(snp_data)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog (all requirements): actual %0d cycles expected fewer", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string rq, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic wait_done(output int n, output logic [15:0] rd, output int ncmd,
                             output logic [1:0] first, output logic [1:0] last,
                             output logic [7:0] wba, output logic [15:0] wbd,
                             output logic [7:0] maddr);
        n = 0; ncmd = 0; first = 0; last = 0; wba = 0; wbd = 0; maddr = 0; rd = 0;
        while (n < 200) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (bus_cmd != 2'd0) begin
                if (ncmd == 0) first = bus_cmd;
                last = bus_cmd;
                ncmd++;
                if (bus_cmd == 2'd3) begin
                    wba = bus_addr;
                    wbd = bus_data;
                    mem[bus_addr] = bus_data;
                end else begin
                    maddr = bus_addr;
                end
            end
            if (cpu_ready) begin
                rd = cpu_rdata;
                cpu_req = 1'b0;
                break;
            end
        end
    endtask

    task automatic access(input logic we, input logic [7:0] addr, input logic [15:0] wd, input string rq);
        int idx;
        logic [4:0] tg;
        bit hit, wb;
        logic [15:0] exp_rd, vdat, rd, wbd;
        logic [7:0] vaddr, wba, maddr;
        logic [1:0] first, last;
        int n, ncmd;
        idx    = int'(addr[2:0]);
        tg     = addr[7:3];
        hit    = we ? (m_st[idx] == 2 && m_tag[idx] == tg) : (m_st[idx] != 0 && m_tag[idx] == tg);
        wb     = !hit && m_st[idx] == 2;
        vaddr  = {m_tag[idx], addr[2:0]};
        vdat   = m_dat[idx];
        exp_rd = hit ? m_dat[idx] : mem[addr];
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        wait_done(n, rd, ncmd, first, last, wba, wbd, maddr);
        check(n == (hit ? 1 : (wb ? 4 : 3)), rq, "latency", n, hit ? 1 : (wb ? 4 : 3));
        check(ncmd == (hit ? 0 : (wb ? 2 : 1)), rq, "bus command count", ncmd, hit ? 0 : (wb ? 2 : 1));
        if (!hit) begin
            check(last == (we ? 2'd2 : 2'd1), rq, "miss command", int'(last), we ? 2 : 1);
            check(maddr == addr, rq, "miss address", int'(maddr), int'(addr));
        end
        if (wb) begin
            check(first == 2'd3, rq, "write-back first", int'(first), 3);
            check(wba == vaddr, rq, "write-back address", int'(wba), int'(vaddr));
            check(wbd == vdat, rq, "write-back data", int'(wbd), int'(vdat));
        end
        if (!we) check(rd == exp_rd, rq, "read data", int'(rd), int'(exp_rd));
        m_tag[idx] = tg;
        if (we) begin
            m_st[idx]  = 2;
            m_dat[idx] = wd;
        end else if (!hit) begin
            m_st[idx]  = 1;
            m_dat[idx] = exp_rd;
        end
    endtask

    task automatic snoop(input logic [1:0] cmd, input logic [7:0] addr, input string rq);
        int idx;
        bit match, sup;
        idx   = int'(addr[2:0]);
        match = m_st[idx] != 0 && m_tag[idx] == addr[7:3];
        sup   = match && m_st[idx] == 2 && (cmd == 2'd1 || cmd == 2'd2);
        @(negedge clk);
        snoop_cmd = cmd; snoop_addr = addr;
        @(negedge clk);
        snoop_cmd = 2'd0;
        check(snp_supply == sup, rq, "supply", int'(snp_supply), int'(sup));
        check(snp_abort == sup, rq, "abort", int'(snp_abort), int'(sup));
        if (sup) begin
            check(snp_data == m_dat[idx], rq, "supplied data", int'(snp_data), int'(m_dat[idx]));
            mem[addr] = snp_data;
        end
        if (match && cmd == 2'd2) m_st[idx] = 0;
        else if (sup) m_st[idx] = 1;
    endtask

    initial begin
        logic [7:0] a, b, c;
        int n, ncmd;
        logic [15:0] rd, wbd;
        logic [7:0] wba, maddr;
        logic [1:0] first, last;
        rst_n = 1'b0; cpu_req = 0; cpu_we = 0; cpu_addr = 0; cpu_wdata = 0;
        snoop_cmd = 0; snoop_addr = 0; hold_gnt = 0;
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 37 + 5);
        for (int i = 0; i < 8; i++) begin m_st[i] = 0; m_tag[i] = 0; m_dat[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(bus_req == 0 && bus_cmd == 0, "R1", "bus idle after reset", int'(bus_cmd), 0);
        check(cpu_ready == 0 && snp_abort == 0 && snp_supply == 0, "R1", "outputs idle after reset",
              int'(snp_abort), 0);

        for (int i = 0; i < 8; i++) begin
            a = {5'(i), 3'(i)};
            b = {5'(i + 8), 3'(i)};
            c = {5'(i + 16), 3'(i)};
            access(0, a, 0, "R1 R2 cold read miss");
            access(0, a, 0, "R2 read hit on shared");
            access(1, a, 16'(16'h1000 + i), "R3 write to shared");
            access(1, a, 16'(16'h2000 + i), "R4 write hit exclusive");
            access(0, a, 0, "R4 read hit exclusive");
            access(0, b, 0, "R5 read evicts dirty line");
            access(0, c, 0, "R6 read evicts clean line");
            snoop(2'd1, c, "R12 read snoop on shared");
            snoop(2'd2, b, "R12 snoop with other tag");
            snoop(2'd2, c, "R7 write snoop on shared");
            access(0, c, 0, "R7 read after invalidate");
            access(1, a, 16'(16'h3000 + i), "R3 write evicts shared");
            access(1, b, 16'(16'h4000 + i), "R5 write evicts dirty line");
            snoop(2'd1, b, "R8 read snoop on exclusive");
            access(0, b, 0, "R8 read hit after downgrade");
            access(1, b, 16'(16'h5000 + i), "R8 write after downgrade goes to bus");
            snoop(2'd2, b, "R9 write snoop on exclusive");
            access(0, b, 0, "R9 read after snooped write");
        end

        // R10: wait for grant, then a snoop on the pending line forces a restart
        b = {5'd8, 3'd0};
        hold_gnt = 1'b1;
        @(negedge clk);
        cpu_req = 1; cpu_we = 1; cpu_addr = b; cpu_wdata = 16'hBEEF;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(bus_req == 1, "R10", "request held while waiting", int'(bus_req), 1);
            check(bus_cmd == 0, "R10", "no command before grant", int'(bus_cmd), 0);
        end
        snoop(2'd2, b, "R10 snoop hits pending block");
        check(bus_req == 0, "R10", "request dropped for restart", int'(bus_req), 0);
        hold_gnt = 1'b0;
        wait_done(n, rd, ncmd, first, last, wba, wbd, maddr);
        check(ncmd == 1 && last == 2'd2, "R10", "restarted write miss", int'(last), 2);
        check(maddr == b, "R10", "restarted miss address", int'(maddr), int'(b));
        m_st[0] = 2; m_tag[0] = 5'd8; m_dat[0] = 16'hBEEF;
        access(0, b, 0, "R10 value written after restart");

        // R11: snoop and processor request in the same cycle, no conflict
        @(negedge clk);
        cpu_req = 1; cpu_we = 0; cpu_addr = {5'd9, 3'd1};
        snoop_cmd = 2'd1; snoop_addr = {5'd10, 3'd2};
        @(negedge clk);
        snoop_cmd = 2'd0;
        check(cpu_ready == 0, "R11", "processor stalled in snoop cycle", int'(cpu_ready), 0);
        check(snp_abort == 0, "R12", "no abort on shared read snoop", int'(snp_abort), 0);
        wait_done(n, rd, ncmd, first, last, wba, wbd, maddr);
        check(n == 1 && ncmd == 0, "R11", "hit served one cycle later", n, 1);
        check(rd == m_dat[1], "R11", "read data after stall", int'(rd), int'(m_dat[1]));

        // R11: snoop invalidates the same line the stalled read wants
        @(negedge clk);
        cpu_req = 1; cpu_we = 0; cpu_addr = {5'd9, 3'd1};
        snoop_cmd = 2'd2; snoop_addr = {5'd9, 3'd1};
        @(negedge clk);
        snoop_cmd = 2'd0;
        check(snp_supply == 0, "R7", "no supply from shared line", int'(snp_supply), 0);
        wait_done(n, rd, ncmd, first, last, wba, wbd, maddr);
        check(ncmd == 1 && last == 2'd1, "R11", "read misses after snoop won", int'(last), 1);
        check(rd == mem[{5'd9, 3'd1}], "R11", "filled data", int'(rd), int'(mem[{5'd9, 3'd1}]));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule